// File: doc/BRIEF.md
# I2C Master Command Queue Front-End

This block sits between a register write port and the byte-level engine of an I2C master. Software writes 10-bit command words. Each word carries a data byte, a read-request bit and a stop-after-this-byte bit. The words are queued in a transmit command FIFO. The engine sees the oldest word, decoded into its three fields, and takes it when it is ready. Bytes that the engine reads off the bus are pushed into a receive FIFO, which the host drains one byte at a time.

Both fill levels are visible. Two threshold flags tell the host when to refill the command queue and when to drain received data. A transmit abort from the engine discards the contents of both queues at once. The block also holds the target address and a 10-bit addressing mode bit. Both may be written only while the block is disabled.

Top module: `i2c_cmdq_frontend`

## Requirements
- R1: After reset both levels are 0, `tx_below_thr` is 1, `rx_above_thr` is 0, `tx_ovf` and `rx_unf` are 0, `tgt_addr` is 0, `ten_bit_mode` is 0 and `eng_valid` is 0.
- R2: A command word is decoded as follows. Bit 9 is the stop request (`eng_stop`). Bit 8 set means a read byte request (`eng_is_read`=1), and then bits 7:0 are ignored and `eng_byte` shows 0. Bit 8 clear means a write, with the byte in bits 7:0 on `eng_byte`.
- R3: Commands reach the engine in write order. `tx_level` counts the stored words and changes on the clock edge after an accepted write or take. `eng_valid` is 1 exactly when `tx_level` is nonzero.
- R4: `tx_below_thr` is 1 exactly when `tx_level` <= `tx_thresh`.
- R5: `rx_above_thr` is 1 exactly when `rx_level` > `rx_thresh`.
- R6: A read request uses one transmit entry like any other command. Each `eng_rx_valid` pulse pushes `eng_rx_byte` into the receive FIFO. `host_rdata` shows the oldest byte, and `host_rd` removes it.
- R7: A command write while the transmit FIFO is full is dropped and sets `tx_ovf`. The flag holds until `flag_clr`.
- R8: A host read while the receive FIFO is empty returns 0 on `host_rdata` and sets `rx_unf`. The flag holds until `flag_clr`.
- R9: An `eng_abort` cycle empties both FIFOs by the next edge. It overrides any write, take, receive push or host read in the same cycle.
- R10: `cfg_we` loads `tgt_addr` and `ten_bit_mode` (1 = 10-bit target addressing, 0 = 7-bit) only while `en` is 0. While `en` is 1 it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enabled; locks the configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 10 | Target address to load |
| cfg_ten | input | 1 | 10-bit addressing select to load |
| tgt_addr | output | 10 | Held target address |
| ten_bit_mode | output | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| cmd_we | input | 1 | Command word write strobe |
| cmd_word | input | 10 | Command word {stop, read, byte} |
| host_rd | input | 1 | Remove the oldest received byte |
| host_rdata | output | 8 | Oldest received byte, 0 when empty |
| tx_thresh | input | clog2(TX_DEPTH)+1 | Transmit low-water threshold |
| rx_thresh | input | clog2(RX_DEPTH)+1 | Receive high-water threshold |
| tx_level | output | clog2(TX_DEPTH)+1 | Stored command words |
| rx_level | output | clog2(RX_DEPTH)+1 | Stored received bytes |
| tx_below_thr | output | 1 | tx_level <= tx_thresh |
| rx_above_thr | output | 1 | rx_level > rx_thresh |
| tx_ovf | output | 1 | Sticky: write to a full command queue |
| rx_unf | output | 1 | Sticky: read of an empty receive queue |
| flag_clr | input | 1 | Clears both sticky flags |
| eng_valid | output | 1 | A command is waiting for the engine |
| eng_is_read | output | 1 | Head command is a read request |
| eng_stop | output | 1 | Head command asks for STOP afterwards |
| eng_byte | output | 8 | Head write byte (0 for reads) |
| eng_take | input | 1 | Engine consumes the head command |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_abort | input | 1 | Transmit abort: flush both FIFOs |

## Verification
The decode is tested with a write word and with a read word whose low byte is all ones. This shows whether the low bits are masked for reads and whether the stop bit lands in the right field. The threshold flags are checked at the levels just below, at and above each threshold, which exposes an off-by-one between <= and <. Five writes into a four-entry queue, drained in order, show that the dropped word is the newest and not the oldest. An abort issued together with a write and a receive push shows that the flush takes priority over both.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
   localparam int BYTE_W   = 8;
   localparam int CMD_W    = 10;
   localparam int ADDR_W   = 10;

   // Field positions are fixed by the command format: {stop, read, byte}
   typedef struct packed {
      logic              stop;
      logic              rd;
      logic [BYTE_W-1:0] data;
   } cmd_t;

   function automatic logic [BYTE_W-1:0] write_byte(cmd_t c);
      return c.rd ? '0 : c.data;
   endfunction
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic [$clog2(DEPTH):0]     level,
   output logic                       full,
   output logic                       empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int LW = AW + 1;
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("cmdq_fifo: DEPTH must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("cmdq_fifo: W must be positive");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [LW-1:0] cnt;
   logic          do_push, do_pop;

   function automatic logic [AW-1:0] step(logic [AW-1:0] p);
      logic [AW-1:0] n;
      if ((1 << AW) == DEPTH) n = p + 1'b1;
      else                    n = (p == LAST) ? '0 : p + 1'b1;
      return n;
   endfunction

   assign full    = (cnt == LW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign dout    = mem[rp];
   assign level   = cnt;

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= step(wp);
         if (do_pop)  rp <= step(rp);
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));
   a_r3_push_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full && !pop && !flush) |=> level == $past(level) + 1'b1);
   a_r7_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> level == LW'(DEPTH));
   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> level == '0);
endmodule

// File: rtl/cmdq_cfg.sv
module cmdq_cfg #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              ten_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic              ten_q
);
   generate
      if (ADDR_W < 10) begin : g_bad_addr
         $error("cmdq_cfg: ADDR_W must hold a 10-bit address");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         ten_q  <= 1'b0;
      end else if (we && !en) begin
         addr_q <= addr_in;
         ten_q  <= ten_in;
      end
   end

   a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> ($stable(addr_q) && $stable(ten_q)));
endmodule

// File: rtl/i2c_cmdq_frontend.sv
module i2c_cmdq_frontend
   import i2cq_pkg::*;
#(
   parameter int TX_DEPTH = 4,
   parameter int RX_DEPTH = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         en,
   input  logic                         cfg_we,
   input  logic [9:0]                   cfg_addr,
   input  logic                         cfg_ten,
   output logic [9:0]                   tgt_addr,
   output logic                         ten_bit_mode,
   input  logic                         cmd_we,
   input  logic [9:0]                   cmd_word,
   input  logic                         host_rd,
   output logic [7:0]                   host_rdata,
   input  logic [$clog2(TX_DEPTH):0]    tx_thresh,
   input  logic [$clog2(RX_DEPTH):0]    rx_thresh,
   output logic [$clog2(TX_DEPTH):0]    tx_level,
   output logic [$clog2(RX_DEPTH):0]    rx_level,
   output logic                         tx_below_thr,
   output logic                         rx_above_thr,
   output logic                         tx_ovf,
   output logic                         rx_unf,
   input  logic                         flag_clr,
   output logic                         eng_valid,
   output logic                         eng_is_read,
   output logic                         eng_stop,
   output logic [7:0]                   eng_byte,
   input  logic                         eng_take,
   input  logic                         eng_rx_valid,
   input  logic [7:0]                   eng_rx_byte,
   input  logic                         eng_abort
);
   generate
      if (CMD_W != BYTE_W + 2) begin : g_bad_cmd
         $error("i2c_cmdq_frontend: command word must be byte plus two flags");
      end
   endgenerate

   cmd_t              tx_head;
   logic [CMD_W-1:0]  tx_dout;
   logic [BYTE_W-1:0] rx_dout;
   logic              tx_full, tx_empty, rx_full, rx_empty;

   cmdq_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(eng_abort),
      .push(cmd_we), .din(cmd_word),
      .pop(eng_take), .dout(tx_dout),
      .level(tx_level), .full(tx_full), .empty(tx_empty));

   cmdq_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(eng_abort),
      .push(eng_rx_valid), .din(eng_rx_byte),
      .pop(host_rd), .dout(rx_dout),
      .level(rx_level), .full(rx_full), .empty(rx_empty));

   cmdq_cfg #(.ADDR_W(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .en(en), .we(cfg_we),
      .addr_in(cfg_addr), .ten_in(cfg_ten),
      .addr_q(tgt_addr), .ten_q(ten_bit_mode));

   // Head decode toward the engine
   assign tx_head     = cmd_t'(tx_dout);
   assign eng_valid   = !tx_empty;
   assign eng_is_read = eng_valid && tx_head.rd;
   assign eng_stop    = eng_valid && tx_head.stop;
   assign eng_byte    = eng_valid ? write_byte(tx_head) : '0;

   assign host_rdata  = rx_empty ? '0 : rx_dout;

   assign tx_below_thr = (tx_level <= tx_thresh);
   assign rx_above_thr = (rx_level >  rx_thresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_ovf <= 1'b0;
         rx_unf <= 1'b0;
      end else begin
         tx_ovf <= (tx_ovf && !flag_clr) || (cmd_we && tx_full);
         rx_unf <= (rx_unf && !flag_clr) || (host_rd && rx_empty);
      end
   end

   a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ovf && !flag_clr) |=> tx_ovf);
   a_r8_unf_set: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && rx_level == '0) |=> rx_unf);
   a_r8_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == '0) |-> host_rdata == '0);
   a_r3_valid_tracks_level: assert property (@(posedge clk) disable iff (!rst_n)
      eng_valid == (tx_level != '0));
endmodule

// File: tb/i2c_cmdq_frontend_tb.sv
module i2c_cmdq_frontend_tb;
   localparam int TXD = 4;
   localparam int RXD = 4;

   logic clk = 0;
   logic rst_n = 0;
   logic en = 0, cfg_we = 0, cfg_ten = 0;
   logic [9:0] cfg_addr = '0;
   logic [9:0] tgt_addr;
   logic ten_bit_mode;
   logic cmd_we = 0;
   logic [9:0] cmd_word = '0;
   logic host_rd = 0;
   logic [7:0] host_rdata;
   logic [2:0] tx_thresh = 3'd2, rx_thresh = 3'd1;
   logic [2:0] tx_level, rx_level;
   logic tx_below_thr, rx_above_thr, tx_ovf, rx_unf;
   logic flag_clr = 0;
   logic eng_valid, eng_is_read, eng_stop;
   logic [7:0] eng_byte;
   logic eng_take = 0, eng_rx_valid = 0, eng_abort = 0;
   logic [7:0] eng_rx_byte = '0;

   int n_chk = 0, n_err = 0;

   always #10 clk = ~clk;

   i2c_cmdq_frontend #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_ten(cfg_ten), .tgt_addr(tgt_addr), .ten_bit_mode(ten_bit_mode),
      .cmd_we(cmd_we), .cmd_word(cmd_word), .host_rd(host_rd),
      .host_rdata(host_rdata), .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
      .tx_level(tx_level), .rx_level(rx_level), .tx_below_thr(tx_below_thr),
      .rx_above_thr(rx_above_thr), .tx_ovf(tx_ovf), .rx_unf(rx_unf),
      .flag_clr(flag_clr), .eng_valid(eng_valid), .eng_is_read(eng_is_read),
      .eng_stop(eng_stop), .eng_byte(eng_byte), .eng_take(eng_take),
      .eng_rx_valid(eng_rx_valid), .eng_rx_byte(eng_rx_byte),
      .eng_abort(eng_abort));

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic push(logic [9:0] w);
      cmd_word = w; cmd_we = 1; tick(); cmd_we = 0;
   endtask

   task automatic take();
      eng_take = 1; tick(); eng_take = 0;
   endtask

   task automatic rx_in(logic [7:0] b);
      eng_rx_byte = b; eng_rx_valid = 1; tick(); eng_rx_valid = 0;
   endtask

   task automatic hread();
      host_rd = 1; tick(); host_rd = 0;
   endtask

   task automatic t_reset();
      chk("R1 tx_level", tx_level, 0);
      chk("R1 rx_level", rx_level, 0);
      chk("R1 tx_below_thr", tx_below_thr, 1);
      chk("R1 rx_above_thr", rx_above_thr, 0);
      chk("R1 tx_ovf", tx_ovf, 0);
      chk("R1 rx_unf", rx_unf, 0);
      chk("R1 tgt_addr", tgt_addr, 0);
      chk("R1 ten_bit_mode", ten_bit_mode, 0);
      chk("R1 eng_valid", eng_valid, 0);
   endtask

   task automatic t_decode();
      push(10'h0A5);
      push(10'h3FF);
      chk("R3 level after two writes", tx_level, 2);
      chk("R2 write is_read", eng_is_read, 0);
      chk("R2 write stop", eng_stop, 0);
      chk("R2 write byte", eng_byte, 8'hA5);
      take();
      chk("R3 level after take", tx_level, 1);
      chk("R2 read is_read", eng_is_read, 1);
      chk("R2 read stop", eng_stop, 1);
      chk("R2 read low bits ignored", eng_byte, 0);
      take();
      chk("R3 valid after drain", eng_valid, 0);
   endtask

   task automatic t_tx_thresh();
      tx_thresh = 3'd2;
      push(10'h001);
      push(10'h002);
      chk("R4 level2 thr2", tx_below_thr, 1);
      push(10'h003);
      chk("R4 level3 thr2", tx_below_thr, 0);
      tx_thresh = 3'd3; #1;
      chk("R4 level3 thr3", tx_below_thr, 1);
      for (int i = 0; i < 3; i++) take();
      chk("R3 drained", tx_level, 0);
      tx_thresh = 3'd2;
   endtask

   task automatic t_read_path();
      push(10'h100);
      take();
      rx_in(8'h11);
      chk("R6 rx_level 1", rx_level, 1);
      chk("R5 level1 thr1", rx_above_thr, 0);
      rx_in(8'h22);
      chk("R6 rx_level 2", rx_level, 2);
      chk("R5 level2 thr1", rx_above_thr, 1);
      chk("R6 first byte", host_rdata, 8'h11);
      hread();
      chk("R6 second byte", host_rdata, 8'h22);
      rx_thresh = 3'd0; #1;
      chk("R5 level1 thr0", rx_above_thr, 1);
      hread();
      chk("R6 rx empty", rx_level, 0);
      chk("R5 level0 thr0", rx_above_thr, 0);
      rx_thresh = 3'd1;
   endtask

   task automatic t_overflow();
      for (int i = 1; i <= 5; i++) push(10'(i));
      chk("R7 level capped", tx_level, 4);
      chk("R7 ovf set", tx_ovf, 1);
      for (int i = 1; i <= 4; i++) begin
         chk("R7 kept order", eng_byte, i);
         take();
      end
      chk("R7 newest dropped", eng_valid, 0);
      chk("R7 ovf sticky", tx_ovf, 1);
      flag_clr = 1; tick(); flag_clr = 0;
      chk("R7 ovf cleared", tx_ovf, 0);
   endtask

   task automatic t_underflow();
      chk("R8 empty data", host_rdata, 0);
      hread();
      chk("R8 unf set", rx_unf, 1);
      chk("R8 level stays", rx_level, 0);
      flag_clr = 1; tick(); flag_clr = 0;
      chk("R8 unf cleared", rx_unf, 0);
   endtask

   task automatic t_abort();
      push(10'h011); push(10'h012); push(10'h013);
      rx_in(8'h44); rx_in(8'h55);
      cmd_word = 10'h0EE; cmd_we = 1; eng_rx_byte = 8'h66; eng_rx_valid = 1;
      eng_abort = 1; tick();
      cmd_we = 0; eng_rx_valid = 0; eng_abort = 0;
      chk("R9 tx flushed", tx_level, 0);
      chk("R9 rx flushed", rx_level, 0);
      chk("R9 no head", eng_valid, 0);
      push(10'h0C3);
      chk("R9 fresh after flush", eng_byte, 8'hC3);
      take();
   endtask

   task automatic t_cfg();
      en = 0; cfg_addr = 10'h2A5; cfg_ten = 1; cfg_we = 1; tick(); cfg_we = 0;
      chk("R10 addr loaded", tgt_addr, 10'h2A5);
      chk("R10 ten loaded", ten_bit_mode, 1);
      en = 1; cfg_addr = 10'h011; cfg_ten = 0; cfg_we = 1; tick(); cfg_we = 0;
      chk("R10 addr locked", tgt_addr, 10'h2A5);
      chk("R10 ten locked", ten_bit_mode, 1);
      en = 0;
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1;
      tick();
      t_reset();
      t_decode();
      t_tx_thresh();
      t_read_path();
      t_overflow();
      t_underflow();
      t_abort();
      t_cfg();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule